// File: doc/BRIEF.md
# Cascadable Signed Multiply-Accumulate Slice

A DSP arithmetic slice that multiplies two signed operands and passes the product to a post-adder. The post-adder combines the product with one selected addend: nothing, an external operand, the cascade input arriving from a neighbouring slice, or the slice's own 48-bit accumulator. The product is either added to or subtracted from that addend. The cascade input can be shifted right arithmetically before use, so that a chain of slices can build a multiply wider than one slice. The result drives both the main output and a cascade output that feeds the next slice directly.

There are three optional pipeline stages: operand capture, product capture and output. Each stage has its own enable. A disabled stage is bypassed, so latency from operands to result equals the number of enabled stages. The accumulator register always exists, because it closes the feedback loop. When the output stage is enabled the accumulator also serves as the output register. A load input starts a fresh accumulation. A synchronous clear empties the accumulator and the sticky overflow flag.

Top module: `mac_slice`

## Requirements
- R1: With op_i[1:0]=00 and op_i[2]=0, the result is the 36-bit signed product of a_i and b_i, sign-extended to 48 bits. Both operands are 18-bit two's complement.
- R2: op_i[2]=1 makes the result the selected addend minus the product. With op_i[1:0]=00 this gives the negated product.
- R3: op_i[1:0]=01 selects c_i, read as a signed 48-bit value, as the addend.
- R4: op_i[1:0]=10 selects cas_i as the addend. If op_i[3]=1, cas_i is first shifted right arithmetically by 17 bits with sign extension. If op_i[3]=0 it is used unshifted.
- R5: op_i[1:0]=11 selects the accumulator as the addend. The accumulator takes the result at every clock edge. With load_i=1 the accumulator addend is forced to zero, so the accumulator restarts from plus or minus the product.
- R6: in_en_i, prod_en_i and out_en_i each enable one pipeline stage. A disabled stage is bypassed, so latency from a_i, b_i, c_i, cas_i, op_i and load_i to p_o is the count of enabled stages (0 to 3). With out_en_i=1, p_o shows the accumulator; with out_en_i=0, p_o shows the post-adder result directly.
- R7: cas_o always equals p_o.
- R8: acc_clr_i=1 clears the accumulator and the overflow flag at the next clock edge. rst_ni=0 clears all state asynchronously.
- R9: Results wrap modulo 2^48. A post-adder result outside the signed 48-bit range sets ovf_o from the next clock edge, and ovf_o stays set until it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_en_i | input | 1 | Enable operand capture stage |
| prod_en_i | input | 1 | Enable product capture stage |
| out_en_i | input | 1 | Enable output stage |
| a_i | input | 18 | Signed multiplicand |
| b_i | input | 18 | Signed multiplier |
| c_i | input | 48 | External addend |
| cas_i | input | 48 | Cascade input from previous slice |
| op_i | input | 4 | [1:0] addend select, [2] subtract, [3] shift cascade |
| load_i | input | 1 | Restart accumulation |
| acc_clr_i | input | 1 | Synchronous accumulator and flag clear |
| p_o | output | 48 | Result |
| cas_o | output | 48 | Cascade output to next slice |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
The hardest state to reach is an overflow of the accumulator or post-adder. Random 18-bit products are at most about 2^34 in size, so accumulating them rarely gets near the 2^47 boundary. The stimulus therefore adds a directed case: an external addend placed just below the limit, followed by a unit product, to force a wrap and set the sticky flag. A clear follows. Random runs cover all eight pipeline enable combinations, each starting from reset, so that the bench's delayed-history model lines up with the stage count.

// File: rtl/mac_slice_pkg.sv
package mac_slice_pkg;
  localparam int OP_W = 4;

  typedef enum logic [1:0] {
    ADD_NONE = 2'b00,
    ADD_C    = 2'b01,
    ADD_CAS  = 2'b10,
    ADD_ACC  = 2'b11
  } addend_sel_e;

  typedef struct packed {
    logic        shift;
    logic        sub;
    addend_sel_e sel;
  } op_t;
endpackage

// File: rtl/mac_pipe_stage.sv
// Register that is always clocked; en selects registered or bypass path.
module mac_pipe_stage #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_r;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_r <= '0;
    else         q_r <= d_i;
  end

  assign q_o = en_i ? q_r : d_i;
endmodule

// File: rtl/mac_mult.sv
module mac_mult #(
  parameter int A_W = 18,
  parameter int B_W = 18,
  localparam int M_W = A_W + B_W
) (
  input  logic [A_W-1:0] a_i,
  input  logic [B_W-1:0] b_i,
  output logic [M_W-1:0] p_o
);
  logic signed [M_W-1:0] prod;
  assign prod = $signed(a_i) * $signed(b_i);
  assign p_o  = prod;
endmodule

// File: rtl/mac_post_add.sv
module mac_post_add
  import mac_slice_pkg::*;
#(
  parameter int P_W   = 48,
  parameter int M_W   = 36,
  parameter int SHIFT = 17
) (
  input  logic [M_W-1:0] prod_i,
  input  logic [P_W-1:0] c_i,
  input  logic [P_W-1:0] cas_i,
  input  logic [P_W-1:0] acc_i,
  input  op_t            op_i,
  input  logic           load_i,
  output logic [P_W-1:0] sum_o,
  output logic           ovf_o
);
  localparam int X_W = P_W + 1;

  logic signed [P_W-1:0] cas_sh, addend;
  logic signed [X_W-1:0] add_x, prod_x, sum_x;

  always_comb begin
    cas_sh = op_i.shift ? ($signed(cas_i) >>> SHIFT) : $signed(cas_i);
    unique case (op_i.sel)
      ADD_NONE: addend = '0;
      ADD_C:    addend = $signed(c_i);
      ADD_CAS:  addend = cas_sh;
      default:  addend = load_i ? '0 : $signed(acc_i);
    endcase
    add_x  = {addend[P_W-1], addend};
    prod_x = {{(X_W-M_W){prod_i[M_W-1]}}, prod_i};
    sum_x  = op_i.sub ? (add_x - prod_x) : (add_x + prod_x);
  end

  // one extra bit: top two bits differ on signed overflow
  assign sum_o = sum_x[P_W-1:0];
  assign ovf_o = sum_x[P_W] ^ sum_x[P_W-1];
endmodule

// File: rtl/mac_slice.sv
module mac_slice
  import mac_slice_pkg::*;
#(
  parameter int A_W       = 18,
  parameter int B_W       = 18,
  parameter int P_W       = 48,
  parameter int CAS_SHIFT = 17
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           in_en_i,
  input  logic           prod_en_i,
  input  logic           out_en_i,
  input  logic [A_W-1:0] a_i,
  input  logic [B_W-1:0] b_i,
  input  logic [P_W-1:0] c_i,
  input  logic [P_W-1:0] cas_i,
  input  logic [3:0]     op_i,
  input  logic           load_i,
  input  logic           acc_clr_i,
  output logic [P_W-1:0] p_o,
  output logic [P_W-1:0] cas_o,
  output logic           ovf_o
);
  localparam int M_W  = A_W + B_W;
  localparam int S1_W = A_W + B_W + 2*P_W + OP_W + 1;
  localparam int S2_W = M_W + 2*P_W + OP_W + 1;

  // operand stage
  logic [S1_W-1:0] s1_d, s1_q;
  logic [A_W-1:0]  a1;
  logic [B_W-1:0]  b1;
  logic [P_W-1:0]  c1, cas1;
  logic [OP_W-1:0] op1;
  logic            ld1;

  assign s1_d = {a_i, b_i, c_i, cas_i, op_i, load_i};

  mac_pipe_stage #(.W(S1_W)) u_in_stage (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (in_en_i),
    .d_i   (s1_d),
    .q_o   (s1_q)
  );

  assign {a1, b1, c1, cas1, op1, ld1} = s1_q;

  logic [M_W-1:0] prod1;

  mac_mult #(.A_W(A_W), .B_W(B_W)) u_mult (
    .a_i(a1),
    .b_i(b1),
    .p_o(prod1)
  );

  // product stage
  logic [S2_W-1:0] s2_d, s2_q;
  logic [M_W-1:0]  prod2;
  logic [P_W-1:0]  c2, cas2;
  logic [OP_W-1:0] op2;
  logic            ld2;

  assign s2_d = {prod1, c1, cas1, op1, ld1};

  mac_pipe_stage #(.W(S2_W)) u_prod_stage (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (prod_en_i),
    .d_i   (s2_d),
    .q_o   (s2_q)
  );

  assign {prod2, c2, cas2, op2, ld2} = s2_q;

  // post-adder
  logic [P_W-1:0] acc_q, sum_w;
  logic           add_ovf_w, ovf_q;

  mac_post_add #(.P_W(P_W), .M_W(M_W), .SHIFT(CAS_SHIFT)) u_post_add (
    .prod_i(prod2),
    .c_i   (c2),
    .cas_i (cas2),
    .acc_i (acc_q),
    .op_i  (op_t'(op2)),
    .load_i(ld2),
    .sum_o (sum_w),
    .ovf_o (add_ovf_w)
  );

  // accumulator doubles as output register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      ovf_q <= 1'b0;
    end else if (acc_clr_i) begin
      acc_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      acc_q <= sum_w;
      ovf_q <= ovf_q | add_ovf_w;
    end
  end

  assign p_o   = out_en_i ? acc_q : sum_w;
  assign cas_o = p_o;
  assign ovf_o = ovf_q;
endmodule

// File: rtl/mac_slice_chk.sv
module mac_slice_chk #(
  parameter int P_W = 48
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           acc_clr_i,
  input logic           out_en_i,
  input logic [P_W-1:0] p_o,
  input logic           ovf_o,
  input logic [P_W-1:0] sum_w,
  input logic           add_ovf_w
);
  p_clr_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_clr_i |=> !ovf_o);

  p_clr_out_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_clr_i && out_en_i) |=> (out_en_i -> p_o == '0));

  p_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !acc_clr_i) |=> ovf_o);

  p_ovf_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (add_ovf_w && !acc_clr_i) |=> ovf_o);

  p_out_reg_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!acc_clr_i) |=> (out_en_i -> p_o == $past(sum_w)));
endmodule

bind mac_slice mac_slice_chk #(.P_W(P_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .acc_clr_i(acc_clr_i),
  .out_en_i (out_en_i),
  .p_o      (p_o),
  .ovf_o    (ovf_o),
  .sum_w    (sum_w),
  .add_ovf_w(add_ovf_w)
);

// File: tb/mac_slice_test.sv
`timescale 1ns/1ps
module mac_slice_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_en_i = 1'b0, prod_en_i = 1'b0, out_en_i = 1'b0;
  logic [17:0] a_i = '0, b_i = '0;
  logic [47:0] c_i = '0, cas_i = '0;
  logic [3:0]  op_i = '0;
  logic        load_i = 1'b0, acc_clr_i = 1'b0;
  logic [47:0] p_o, cas_o;
  logic        ovf_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  mac_slice uut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .in_en_i(in_en_i), .prod_en_i(prod_en_i), .out_en_i(out_en_i),
    .a_i(a_i), .b_i(b_i), .c_i(c_i), .cas_i(cas_i), .op_i(op_i),
    .load_i(load_i), .acc_clr_i(acc_clr_i),
    .p_o(p_o), .cas_o(cas_o), .ovf_o(ovf_o)
  );

  // input history: index k = value driven k cycles ago
  logic [17:0] ha [3];
  logic [17:0] hb [3];
  logic [47:0] hc [3];
  logic [47:0] hcas [3];
  logic [3:0]  hop [3];
  logic        hld [3];
  logic [47:0] m_acc;
  logic        m_ovf;

  localparam longint MAXV = (64'sd1 <<< 47) - 1;
  localparam longint MINV = -(64'sd1 <<< 47);

  function automatic longint sx48(input logic [47:0] v);
    return longint'({{16{v[47]}}, v});
  endfunction

  function automatic longint model_sum(input int k, input logic [47:0] acc);
    longint prod, add;
    prod = longint'($signed(ha[k])) * longint'($signed(hb[k]));
    case (hop[k][1:0])
      2'b00: add = 0;
      2'b01: add = sx48(hc[k]);
      2'b10: add = hop[k][3] ? (sx48(hcas[k]) >>> 17) : sx48(hcas[k]);
      default: add = hld[k] ? 0 : sx48(acc);
    endcase
    return hop[k][2] ? (add - prod) : (add + prod);
  endfunction

  task automatic check(input string tag, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic ie, input logic pe, input logic oe);
    @(negedge clk_i);
    rst_ni = 1'b0;
    a_i = '0; b_i = '0; c_i = '0; cas_i = '0; op_i = '0; load_i = 0; acc_clr_i = 0;
    in_en_i = ie; prod_en_i = pe; out_en_i = oe;
    for (int k = 0; k < 3; k++) begin
      ha[k] = '0; hb[k] = '0; hc[k] = '0; hcas[k] = '0; hop[k] = '0; hld[k] = 0;
    end
    m_acc = '0; m_ovf = 0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    check("R8 reset p_o", p_o, '0);
    check("R8 reset ovf_o", {47'd0, ovf_o}, '0);
  endtask

  task automatic cyc(input logic [17:0] ta, input logic [17:0] tb,
                     input logic [47:0] tc, input logic [47:0] tcas,
                     input logic [3:0] top, input logic tld, input logic tclr,
                     input string tag);
    int d;
    longint r;
    logic [47:0] rv, exp;
    @(negedge clk_i);
    a_i = ta; b_i = tb; c_i = tc; cas_i = tcas; op_i = top; load_i = tld; acc_clr_i = tclr;
    for (int k = 2; k > 0; k--) begin
      ha[k] = ha[k-1]; hb[k] = hb[k-1]; hc[k] = hc[k-1];
      hcas[k] = hcas[k-1]; hop[k] = hop[k-1]; hld[k] = hld[k-1];
    end
    ha[0] = ta; hb[0] = tb; hc[0] = tc; hcas[0] = tcas; hop[0] = top; hld[0] = tld;
    d = int'(in_en_i) + int'(prod_en_i);
    r = model_sum(d, m_acc);
    rv = r[47:0];
    exp = out_en_i ? m_acc : rv;
    #1;
    check({tag, " p_o"}, p_o, exp);
    check("R7 cas_o", cas_o, exp);
    check("R9 ovf_o", {47'd0, ovf_o}, {47'd0, m_ovf});
    if (tclr) begin
      m_acc = '0; m_ovf = 0;
    end else begin
      m_acc = rv;
      m_ovf = m_ovf | (r > MAXV) | (r < MINV);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [47:0] w;
    void'($urandom(32'd2024));

    // R1 R2: combinational path, directed extremes
    do_reset(0, 0, 0);
    cyc(18'h20000, 18'h20000, '0, '0, 4'b0000, 0, 0, "R1 min*min");
    cyc(18'h20000, 18'h1FFFF, '0, '0, 4'b0000, 0, 0, "R1 min*max");
    cyc(18'h3FFFF, 18'h00005, '0, '0, 4'b0100, 0, 0, "R2 negate");
    cyc(18'h00007, 18'h00003, 48'd100, '0, 4'b0101, 0, 0, "R2 c minus prod");
    cyc(18'h00002, 18'h3FFFD, 48'hFFFF_FFFF_FFF0, '0, 4'b0001, 0, 0, "R3 c plus prod");
    // R4 cascade shifted and unshifted
    cyc('0, '0, '0, 48'h8000_0000_0000, 4'b1010, 0, 0, "R4 shift sign");
    cyc(18'd1, 18'd1, '0, 48'h0000_0123_4567, 4'b1010, 0, 0, "R4 shift pos");
    cyc(18'd1, 18'd1, '0, 48'h0000_0123_4567, 4'b0010, 0, 0, "R4 no shift");
    // R5 accumulate then load restart
    for (int i = 0; i < 5; i++) cyc(18'd1000, 18'd3, '0, '0, 4'b0011, 0, 0, "R5 accumulate");
    cyc(18'd9, 18'd9, '0, '0, 4'b0011, 1, 0, "R5 load");
    cyc(18'd9, 18'd9, '0, '0, 4'b0111, 0, 0, "R5 acc minus");

    // R9 overflow wrap and sticky flag, then R8 clear
    do_reset(0, 0, 1);
    cyc(18'd1, 18'd1, 48'h7FFF_FFFF_FFFF, '0, 4'b0001, 0, 0, "R9 wrap");
    cyc('0, '0, '0, '0, 4'b0000, 0, 0, "R9 wrapped value");
    cyc('0, '0, '0, '0, 4'b0011, 0, 0, "R9 sticky");
    cyc('0, '0, '0, '0, 4'b0011, 0, 1, "R8 clear");
    cyc('0, '0, '0, '0, 4'b0011, 0, 0, "R8 after clear");
    check("R8 flag cleared", {47'd0, ovf_o}, '0);

    // R6 all stage combinations with random traffic
    for (int cfg = 0; cfg < 8; cfg++) begin
      do_reset(cfg[0], cfg[1], cfg[2]);
      for (int i = 0; i < 400; i++) begin
        w = {$urandom, $urandom};
        cyc($urandom, $urandom, w, {$urandom, $urandom}, 4'($urandom),
            ($urandom % 4) == 0, ($urandom % 32) == 0, "R6 random");
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule